// File: doc/BRIEF.md
# SD Host Interrupt and Register Core

This block is the register and interrupt core of an SD host controller. It owns a 32-bit register window with the global control word, timing and block-geometry settings, the interrupt mask, a raw interrupt status word, a card status word and an internal-DMA status word. It also keeps a transfer byte counter that the data path decrements, and it drives one level-sensitive interrupt line toward the system.

Software reaches the core through a simple single-cycle write strobe with a combinational read port. The card-detect logic reports insertion and removal as one-cycle pulses. The command engine and the DMA engine post their completion flags as one-cycle set vectors. Other units take control fields from the core's outputs: DMA enable, timeout, block size, byte count, FIFO watermark and the auto-stop argument. They also receive one-cycle pulses that request a soft, FIFO or DMA reset.

Registers sit on aligned word offsets: control 0x000, timeout 0x004, block size 0x008, byte count 0x00C, interrupt mask 0x010, masked status 0x014, raw status 0x018, card status 0x01C, FIFO watermark 0x020, auto-stop argument 0x024, DMA status 0x028, transfer counter 0x02C (read-only). A ten-word CRC window starts at 0x100.

Top module: `sdh_regcore`

## Requirements
- R1: After reset the registers read as follows: control 0x00000300, timeout 0xFFFFFF40, block size 0x200, byte count 0x200, card status 0x100, FIFO watermark 0x000F0000, auto-stop argument 0x0000FFFF. The transfer counter reads 0 and every other register reads 0. irq_o is low.
- R2: irq_o is a register. One clock after any write or event, it equals the OR of (raw status AND mask), forced to 0 when control bit 4 is clear.
- R3: Reading the masked status offset returns raw AND mask. A write to either the masked or the raw status offset clears every raw bit whose data bit is 1. No other raw bit changes.
- R4: Control bits 2:0 always read back as 0. A control write with bit 0, 1 or 2 set pulses soft_rst_o, fifo_rst_o or dma_rst_o for exactly the next cycle. All other control bits are stored as written.
- R5: card_ins_i sets raw bit 30, clears raw bit 31 and sets card status bit 8. card_rem_i clears raw bit 30, sets raw bit 31 and clears card status bit 8.
- R6: A byte-count write stores the value and also loads the transfer counter with it.
- R7: Each xfer_dec_i pulse lowers the transfer counter by xfer_amt_i and stops at 0. A decrement that leaves the counter at 0 sets raw bit 3, even when the counter was already 0. A byte-count write in the same cycle takes priority over the decrement.
- R8: dma_set_i sets DMA status bits. A DMA status write clears only bits 9:0 whose data bit is 1, and preserves bits 31:10.
- R9: A card status write clears every card status bit whose data bit is 1.
- R10: The CRC window, undefined offsets and unaligned offsets read as 0, and writes to them change nothing. Writes to the transfer counter offset are ignored.
- R11: raw_set_i sets raw status bits. If a set and a write-one-to-clear hit the same bit in one cycle, the bit ends set.
- R12: The timeout, block size, FIFO watermark, auto-stop argument and mask registers read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Byte address of access |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| card_ins_i | input | 1 | Card inserted pulse |
| card_rem_i | input | 1 | Card removed pulse |
| raw_set_i | input | 32 | Raw status set pulses from command and DMA units |
| dma_set_i | input | 32 | DMA status set pulses |
| xfer_dec_i | input | 1 | Decrement transfer counter |
| xfer_amt_i | input | 16 | Bytes moved by this decrement |
| irq_o | output | 1 | Level interrupt |
| dma_en_o | output | 1 | DMA enable (control bit 5) |
| timeout_o | output | 32 | Timeout setting |
| blk_size_o | output | 32 | Block size |
| byte_cnt_o | output | 32 | Byte count setting |
| fifo_wm_o | output | 32 | FIFO watermark setting |
| astop_arg_o | output | 32 | Auto-stop command argument |
| xfer_cnt_o | output | 32 | Remaining transfer bytes |
| soft_rst_o | output | 1 | Soft reset request pulse |
| fifo_rst_o | output | 1 | FIFO reset request pulse |
| dma_rst_o | output | 1 | DMA reset request pulse |

## Verification
A stuck or lost raw status bit reaches irq_o within one clock. It can also be read directly from the raw or masked status offsets. A wrong transfer count stays hidden until the counter's read-only offset is read or data-complete fires early or late. For that reason the bench reads the counter after every burst of decrements. Set-versus-clear ordering and the self-clearing control bits can only be told apart in the cycle of the collision. Both get directed same-cycle stimulus alongside the seeded random traffic.

// File: rtl/sdh_regcore_pkg.sv
package sdh_regcore_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFF_CTRL  = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_TMO   = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_BLK   = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_BYTE  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFF_MASK  = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_MSTAT = 12'h014;
  localparam logic [ADDR_W-1:0] OFF_RSTAT = 12'h018;
  localparam logic [ADDR_W-1:0] OFF_CSTAT = 12'h01C;
  localparam logic [ADDR_W-1:0] OFF_FWM   = 12'h020;
  localparam logic [ADDR_W-1:0] OFF_ASARG = 12'h024;
  localparam logic [ADDR_W-1:0] OFF_DSTAT = 12'h028;
  localparam logic [ADDR_W-1:0] OFF_XCNT  = 12'h02C;
  localparam logic [ADDR_W-1:0] OFF_CRC   = 12'h100;
  localparam int unsigned       CRC_WORDS = 10;

  localparam int unsigned CTRL_SELFCLR_N = 3;   // bits 0..2
  localparam int unsigned CTRL_IRQ_EN    = 4;
  localparam int unsigned CTRL_DMA_EN    = 5;
  localparam int unsigned RAW_DATA_DONE  = 3;
  localparam int unsigned RAW_CARD_IN    = 30;
  localparam int unsigned RAW_CARD_OUT   = 31;
  localparam int unsigned CST_PRESENT    = 8;
  localparam int unsigned DMA_CLR_W      = 10;

  localparam logic [REG_W-1:0] CTRL_RST  = 32'h0000_0300;
  localparam logic [REG_W-1:0] TMO_RST   = 32'hFFFF_FF40;
  localparam logic [REG_W-1:0] BLK_RST   = 32'h0000_0200;
  localparam logic [REG_W-1:0] BYTE_RST  = 32'h0000_0200;
  localparam logic [REG_W-1:0] CST_RST   = 32'h0000_0100;
  localparam logic [REG_W-1:0] FWM_RST   = 32'h000F_0000;
  localparam logic [REG_W-1:0] ASARG_RST = 32'h0000_FFFF;
endpackage

// File: rtl/sdh_ctrl_regs.sv
module sdh_ctrl_regs
  import sdh_regcore_pkg::*;
#(
  parameter int unsigned DW = REG_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_ctrl_i,
  input  logic          wr_tmo_i,
  input  logic          wr_blk_i,
  input  logic          wr_byte_i,
  input  logic          wr_fwm_i,
  input  logic          wr_asarg_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] ctrl_q_o,
  output logic [DW-1:0] ctrl_d_o,
  output logic [DW-1:0] tmo_o,
  output logic [DW-1:0] blk_o,
  output logic [DW-1:0] byte_o,
  output logic [DW-1:0] fwm_o,
  output logic [DW-1:0] asarg_o,
  output logic [CTRL_SELFCLR_N-1:0] rst_req_o
);
  localparam int unsigned NPL = 4;
  localparam logic [DW-1:0] SC_KEEP = ~{{(DW-CTRL_SELFCLR_N){1'b0}}, {CTRL_SELFCLR_N{1'b1}}};
  localparam logic [DW-1:0] PL_RST [NPL] = '{TMO_RST, BLK_RST, FWM_RST, ASARG_RST};

  logic [DW-1:0] ctrl_q, byte_q;
  logic [CTRL_SELFCLR_N-1:0] rst_req_q;
  logic [NPL-1:0] pl_we;
  logic [DW-1:0] pl_q [NPL];

  // reset request bits are never stored, only pulsed out
  assign ctrl_d_o = wr_ctrl_i ? (wdata_i & SC_KEEP) : ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= CTRL_RST;
      byte_q    <= BYTE_RST;
      rst_req_q <= '0;
    end else begin
      ctrl_q    <= ctrl_d_o;
      rst_req_q <= wr_ctrl_i ? wdata_i[CTRL_SELFCLR_N-1:0] : '0;
      if (wr_byte_i) byte_q <= wdata_i;
    end
  end

  assign pl_we = {wr_asarg_i, wr_fwm_i, wr_blk_i, wr_tmo_i};

  for (genvar g = 0; g < NPL; g++) begin : g_plain
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= PL_RST[g];
      else if (pl_we[g]) q <= wdata_i;
    end
    assign pl_q[g] = q;
  end

  assign ctrl_q_o  = ctrl_q;
  assign byte_o    = byte_q;
  assign tmo_o     = pl_q[0];
  assign blk_o     = pl_q[1];
  assign fwm_o     = pl_q[2];
  assign asarg_o   = pl_q[3];
  assign rst_req_o = rst_req_q;
endmodule

// File: rtl/sdh_xfer_cnt.sv
module sdh_xfer_cnt #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned AMT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q, amt_ext;
  logic             sat;

  assign amt_ext = CNT_W'(amt_i);
  assign sat     = (cnt_q <= amt_ext);
  // load wins over a same-cycle decrement
  assign done_o  = dec_i && !load_i && sat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= sat ? '0 : cnt_q - amt_ext;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/sdh_irq_ctrl.sv
module sdh_irq_ctrl
  import sdh_regcore_pkg::*;
#(
  parameter int unsigned DW    = REG_W,
  parameter int unsigned CLR_W = DMA_CLR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_mask_i,
  input  logic          wr_rclr_i,
  input  logic          wr_cstat_i,
  input  logic          wr_dstat_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          card_ins_i,
  input  logic          card_rem_i,
  input  logic [DW-1:0] raw_set_i,
  input  logic          data_done_i,
  input  logic [DW-1:0] dma_set_i,
  input  logic          irq_en_d_i,
  output logic [DW-1:0] raw_o,
  output logic [DW-1:0] mask_o,
  output logic [DW-1:0] cstat_o,
  output logic [DW-1:0] dstat_o,
  output logic          irq_o
);
  localparam logic [DW-1:0] DCLR_MASK = {{(DW-CLR_W){1'b0}}, {CLR_W{1'b1}}};

  logic [DW-1:0] raw_q, raw_d, mask_q, mask_d, cst_q, cst_d, dst_q, dst_d;
  logic          irq_q, irq_d;

  always_comb begin
    raw_d = raw_q;
    if (wr_rclr_i) raw_d = raw_d & ~wdata_i;
    raw_d = raw_d | raw_set_i;      // set beats clear
    if (data_done_i) raw_d[RAW_DATA_DONE] = 1'b1;
    if (card_ins_i) begin
      raw_d[RAW_CARD_IN]  = 1'b1;
      raw_d[RAW_CARD_OUT] = 1'b0;
    end else if (card_rem_i) begin
      raw_d[RAW_CARD_IN]  = 1'b0;
      raw_d[RAW_CARD_OUT] = 1'b1;
    end
  end

  always_comb begin
    cst_d = cst_q;
    if (wr_cstat_i) cst_d = cst_d & ~wdata_i;
    if (card_ins_i)      cst_d[CST_PRESENT] = 1'b1;
    else if (card_rem_i) cst_d[CST_PRESENT] = 1'b0;
  end

  always_comb begin
    dst_d = dst_q;
    if (wr_dstat_i) dst_d = dst_d & ~(wdata_i & DCLR_MASK);
    dst_d = dst_d | dma_set_i;
  end

  assign mask_d = wr_mask_i ? wdata_i : mask_q;
  assign irq_d  = irq_en_d_i && |(raw_d & mask_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= '0;
      mask_q <= '0;
      cst_q  <= CST_RST;
      dst_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
      cst_q  <= cst_d;
      dst_q  <= dst_d;
      irq_q  <= irq_d;
    end
  end

  assign raw_o   = raw_q;
  assign mask_o  = mask_q;
  assign cstat_o = cst_q;
  assign dstat_o = dst_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/sdh_regcore.sv
module sdh_regcore
  import sdh_regcore_pkg::*;
#(
  parameter int unsigned DW    = REG_W,
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned AMT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  input  logic             card_ins_i,
  input  logic             card_rem_i,
  input  logic [DW-1:0]    raw_set_i,
  input  logic [DW-1:0]    dma_set_i,
  input  logic             xfer_dec_i,
  input  logic [AMT_W-1:0] xfer_amt_i,
  output logic             irq_o,
  output logic             dma_en_o,
  output logic [DW-1:0]    timeout_o,
  output logic [DW-1:0]    blk_size_o,
  output logic [DW-1:0]    byte_cnt_o,
  output logic [DW-1:0]    fifo_wm_o,
  output logic [DW-1:0]    astop_arg_o,
  output logic [DW-1:0]    xfer_cnt_o,
  output logic             soft_rst_o,
  output logic             fifo_rst_o,
  output logic             dma_rst_o
);
  localparam logic [AW-1:0] CRC_END = OFF_CRC + AW'(4 * CRC_WORDS);

  logic wr_ctrl, wr_tmo, wr_blk, wr_byte, wr_mask, wr_rclr, wr_cstat;
  logic wr_fwm, wr_asarg, wr_dstat;
  logic crc_hit, data_done;
  logic [DW-1:0] ctrl_q, ctrl_d, raw_q, mask_q, cstat_q, dstat_q;
  logic [CTRL_SELFCLR_N-1:0] rst_req;

  assign wr_ctrl  = reg_we_i && (reg_addr_i == OFF_CTRL);
  assign wr_tmo   = reg_we_i && (reg_addr_i == OFF_TMO);
  assign wr_blk   = reg_we_i && (reg_addr_i == OFF_BLK);
  assign wr_byte  = reg_we_i && (reg_addr_i == OFF_BYTE);
  assign wr_mask  = reg_we_i && (reg_addr_i == OFF_MASK);
  assign wr_rclr  = reg_we_i && ((reg_addr_i == OFF_MSTAT) || (reg_addr_i == OFF_RSTAT));
  assign wr_cstat = reg_we_i && (reg_addr_i == OFF_CSTAT);
  assign wr_fwm   = reg_we_i && (reg_addr_i == OFF_FWM);
  assign wr_asarg = reg_we_i && (reg_addr_i == OFF_ASARG);
  assign wr_dstat = reg_we_i && (reg_addr_i == OFF_DSTAT);
  assign crc_hit  = (reg_addr_i >= OFF_CRC) && (reg_addr_i < CRC_END);

  sdh_ctrl_regs #(.DW(DW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_ctrl_i  (wr_ctrl),
    .wr_tmo_i   (wr_tmo),
    .wr_blk_i   (wr_blk),
    .wr_byte_i  (wr_byte),
    .wr_fwm_i   (wr_fwm),
    .wr_asarg_i (wr_asarg),
    .wdata_i    (reg_wdata_i),
    .ctrl_q_o   (ctrl_q),
    .ctrl_d_o   (ctrl_d),
    .tmo_o      (timeout_o),
    .blk_o      (blk_size_o),
    .byte_o     (byte_cnt_o),
    .fwm_o      (fifo_wm_o),
    .asarg_o    (astop_arg_o),
    .rst_req_o  (rst_req)
  );

  sdh_xfer_cnt #(.CNT_W(DW), .AMT_W(AMT_W)) u_xcnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr_byte),
    .load_val_i (reg_wdata_i),
    .dec_i      (xfer_dec_i),
    .amt_i      (xfer_amt_i),
    .cnt_o      (xfer_cnt_o),
    .done_o     (data_done)
  );

  sdh_irq_ctrl #(.DW(DW)) u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_mask_i   (wr_mask),
    .wr_rclr_i   (wr_rclr),
    .wr_cstat_i  (wr_cstat),
    .wr_dstat_i  (wr_dstat),
    .wdata_i     (reg_wdata_i),
    .card_ins_i  (card_ins_i),
    .card_rem_i  (card_rem_i),
    .raw_set_i   (raw_set_i),
    .data_done_i (data_done),
    .dma_set_i   (dma_set_i),
    .irq_en_d_i  (ctrl_d[CTRL_IRQ_EN]),
    .raw_o       (raw_q),
    .mask_o      (mask_q),
    .cstat_o     (cstat_q),
    .dstat_o     (dstat_q),
    .irq_o       (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (!crc_hit) begin
      unique case (reg_addr_i)
        OFF_CTRL:  reg_rdata_o = ctrl_q;
        OFF_TMO:   reg_rdata_o = timeout_o;
        OFF_BLK:   reg_rdata_o = blk_size_o;
        OFF_BYTE:  reg_rdata_o = byte_cnt_o;
        OFF_MASK:  reg_rdata_o = mask_q;
        OFF_MSTAT: reg_rdata_o = raw_q & mask_q;
        OFF_RSTAT: reg_rdata_o = raw_q;
        OFF_CSTAT: reg_rdata_o = cstat_q;
        OFF_FWM:   reg_rdata_o = fifo_wm_o;
        OFF_ASARG: reg_rdata_o = astop_arg_o;
        OFF_DSTAT: reg_rdata_o = dstat_q;
        OFF_XCNT:  reg_rdata_o = xfer_cnt_o;
        default:   reg_rdata_o = '0;
      endcase
    end
  end

  assign dma_en_o   = ctrl_q[CTRL_DMA_EN];
  assign soft_rst_o = rst_req[0];
  assign fifo_rst_o = rst_req[1];
  assign dma_rst_o  = rst_req[2];
endmodule

// File: rtl/sdh_regcore_chk.sv
module sdh_regcore_chk
  import sdh_regcore_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic [11:0] reg_addr_i,
  input logic [31:0] reg_wdata_i,
  input logic [31:0] reg_rdata_o,
  input logic        card_ins_i,
  input logic [31:0] dma_set_i,
  input logic        xfer_dec_i,
  input logic [15:0] xfer_amt_i,
  input logic        irq_o,
  input logic [31:0] xfer_cnt_o,
  input logic [31:0] byte_cnt_o,
  input logic [31:0] ctrl_q,
  input logic [31:0] raw_q,
  input logic [31:0] mask_q,
  input logic [31:0] cstat_q,
  input logic [31:0] dstat_q
);
  assert_irq_level_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (ctrl_q[CTRL_IRQ_EN] && |(raw_q & mask_q)));

  assert_masked_view_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == OFF_MSTAT) |-> (reg_rdata_o == (raw_q & mask_q)));

  assert_ctrl_selfclr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == OFF_CTRL) |=>
      (ctrl_q[2:0] == 3'b000) && (ctrl_q[31:3] == $past(reg_wdata_i[31:3])));

  assert_card_insert_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_ins_i |=> raw_q[RAW_CARD_IN] && !raw_q[RAW_CARD_OUT] && cstat_q[CST_PRESENT]);

  assert_cnt_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == OFF_BYTE) |=>
      (xfer_cnt_o == $past(reg_wdata_i)) && (byte_cnt_o == $past(reg_wdata_i)));

  assert_cnt_saturate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_dec_i && !(reg_we_i && reg_addr_i == OFF_BYTE) && (xfer_cnt_o <= 32'(xfer_amt_i)))
      |=> (xfer_cnt_o == 32'd0) && raw_q[RAW_DATA_DONE]);

  assert_dma_high_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == OFF_DSTAT && dma_set_i == 32'd0) |=>
      (dstat_q[31:10] == $past(dstat_q[31:10])));
endmodule

bind sdh_regcore sdh_regcore_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .card_ins_i  (card_ins_i),
  .dma_set_i   (dma_set_i),
  .xfer_dec_i  (xfer_dec_i),
  .xfer_amt_i  (xfer_amt_i),
  .irq_o       (irq_o),
  .xfer_cnt_o  (xfer_cnt_o),
  .byte_cnt_o  (byte_cnt_o),
  .ctrl_q      (ctrl_q),
  .raw_q       (raw_q),
  .mask_q      (mask_q),
  .cstat_q     (cstat_q),
  .dstat_q     (dstat_q)
);

// File: tb/sim_sdh_regcore.sv
module sim_sdh_regcore;
  localparam int CLK_PERIOD = 10;

  localparam logic [11:0] A_CTRL = 12'h000, A_TMO = 12'h004, A_BLK = 12'h008, A_BYTE = 12'h00C;
  localparam logic [11:0] A_MASK = 12'h010, A_MST = 12'h014, A_RST = 12'h018, A_CST = 12'h01C;
  localparam logic [11:0] A_FWM = 12'h020, A_ASA = 12'h024, A_DST = 12'h028, A_XCNT = 12'h02C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rset = '0, dset = '0;
  logic ins = 1'b0, rem = 1'b0, dec = 1'b0;
  logic [15:0] amt = '0;
  logic [31:0] rdata, tmo, blk, byte_c, fwm, asa, xcnt;
  logic irq, dma_en, soft_r, fifo_r, dma_r;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_ctrl, m_raw, m_mask, m_cst, m_dst, m_x;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdh_regcore u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .card_ins_i(ins), .card_rem_i(rem), .raw_set_i(rset),
    .dma_set_i(dset), .xfer_dec_i(dec), .xfer_amt_i(amt), .irq_o(irq), .dma_en_o(dma_en),
    .timeout_o(tmo), .blk_size_o(blk), .byte_cnt_o(byte_c), .fifo_wm_o(fwm),
    .astop_arg_o(asa), .xfer_cnt_o(xcnt), .soft_rst_o(soft_r), .fifo_rst_o(fifo_r),
    .dma_rst_o(dma_r)
  );

  function automatic logic m_irq();
    return m_ctrl[4] && |(m_raw & m_mask);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
    case (a)
      A_CTRL: m_ctrl = d & ~32'h7;
      A_MASK: m_mask = d;
      A_MST, A_RST: m_raw = m_raw & ~d;
      A_CST: m_cst = m_cst & ~d;
      A_DST: m_dst = m_dst & ~(d & 32'h3FF);
      A_BYTE: m_x = d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic evt(input logic i, input logic r, input logic [31:0] rs,
                     input logic [31:0] ds, input logic dc, input logic [15:0] am);
    @(negedge clk); ins = i; rem = r; rset = rs; dset = ds; dec = dc; amt = am;
    @(negedge clk); ins = 0; rem = 0; rset = '0; dset = '0; dec = 0; amt = '0;
    m_raw = m_raw | rs;
    m_dst = m_dst | ds;
    if (dc) begin
      if (m_x > 32'(am)) m_x = m_x - 32'(am);
      else begin m_x = 0; m_raw[3] = 1'b1; end
    end
    if (i) begin m_raw[30] = 1; m_raw[31] = 0; m_cst[8] = 1; end
    else if (r) begin m_raw[30] = 0; m_raw[31] = 1; m_cst[8] = 0; end
  endtask

  task automatic chk_ro(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_0C0D));
    m_ctrl = 32'h300; m_raw = 0; m_mask = 0; m_cst = 32'h100; m_dst = 0; m_x = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk_ro("R1 ctrl", A_CTRL, 32'h300);
    chk_ro("R1 tmo", A_TMO, 32'hFFFFFF40);
    chk_ro("R1 blk", A_BLK, 32'h200);
    chk_ro("R1 byte", A_BYTE, 32'h200);
    chk_ro("R1 cstat", A_CST, 32'h100);
    chk_ro("R1 fwm", A_FWM, 32'h000F0000);
    chk_ro("R1 asarg", A_ASA, 32'h0000FFFF);
    chk_ro("R1 xcnt", A_XCNT, 32'h0);
    chk_ro("R1 raw", A_RST, 32'h0);
    chk_ro("R1 dstat", A_DST, 32'h0);

    // R12 storage registers
    wr(A_TMO, 32'h1234_5678); wr(A_BLK, 32'h0000_0400);
    wr(A_FWM, 32'h0008_0010); wr(A_ASA, 32'hDEAD_0000); wr(A_MASK, 32'h0000_0004);
    chk_ro("R12 tmo", A_TMO, 32'h1234_5678);
    chk_ro("R12 blk", A_BLK, 32'h0000_0400);
    chk_ro("R12 fwm", A_FWM, 32'h0008_0010);
    chk_ro("R12 asarg", A_ASA, 32'hDEAD_0000);
    chk_ro("R12 mask", A_MASK, 32'h0000_0004);

    // R4 self-clearing control bits with one-cycle pulses
    wr(A_CTRL, 32'h0000_0337);
    chk("R4 pulses", {29'b0, dma_r, fifo_r, soft_r}, 32'h7);
    @(negedge clk);
    chk("R4 pulses end", {29'b0, dma_r, fifo_r, soft_r}, 32'h0);
    chk_ro("R4 ctrl readback", A_CTRL, 32'h0000_0330);
    chk("R4 dma_en", {31'b0, dma_en}, 32'h1);

    // R2 irq rises exactly one cycle after the set pulse
    @(negedge clk); rset = 32'h4; #1;
    chk("R2 irq before edge", {31'b0, irq}, 32'h0);
    @(negedge clk); rset = '0; m_raw = m_raw | 32'h4;
    chk("R2 irq after edge", {31'b0, irq}, 32'h1);
    wr(A_CTRL, 32'h0000_0320);
    chk("R2 irq gated by enable", {31'b0, irq}, 32'h0);
    wr(A_CTRL, 32'h0000_0310);
    chk("R2 irq re-enabled", {31'b0, irq}, 32'h1);

    // R3 masked view and write-one-to-clear via masked offset
    evt(0, 0, 32'h0000_4002, 0, 0, 0);
    chk_ro("R3 masked read", A_MST, 32'h0000_0004);
    chk_ro("R3 raw read", A_RST, 32'h0000_4006);
    wr(A_MST, 32'h0000_0004);
    chk_ro("R3 clear via masked", A_RST, 32'h0000_4002);
    chk("R3 irq dropped", {31'b0, irq}, 32'h0);
    wr(A_RST, 32'h0000_4002);
    chk_ro("R3 clear via raw", A_RST, 32'h0);

    // R11 set beats clear in the same cycle
    @(negedge clk); addr = A_RST; wdata = 32'h0000_0030; we = 1; rset = 32'h0000_0020;
    @(negedge clk); we = 0; rset = '0;
    m_raw = (m_raw & ~32'h30) | 32'h20;
    chk_ro("R11 set wins", A_RST, 32'h0000_0020);
    wr(A_RST, 32'hFFFF_FFFF);

    // R5 card insertion and removal, R9 card status clear
    evt(1, 0, 0, 0, 0, 0);
    chk_ro("R5 insert raw", A_RST, 32'h4000_0000);
    chk_ro("R5 insert present", A_CST, 32'h100);
    evt(0, 1, 0, 0, 0, 0);
    chk_ro("R5 remove raw", A_RST, 32'h8000_0000);
    chk_ro("R5 remove present", A_CST, 32'h0);
    evt(1, 0, 0, 0, 0, 0);
    wr(A_CST, 32'h0000_0100);
    chk_ro("R9 cstat w1c", A_CST, 32'h0);
    wr(A_RST, 32'hFFFF_FFFF);

    // R6, R7 transfer counter
    wr(A_BYTE, 32'd10);
    chk_ro("R6 load", A_XCNT, 32'd10);
    chk("R6 byte_cnt_o", byte_c, 32'd10);
    evt(0, 0, 0, 0, 1, 16'd4);
    chk_ro("R7 dec", A_XCNT, 32'd6);
    chk_ro("R7 no done yet", A_RST, 32'h0);
    evt(0, 0, 0, 0, 1, 16'd4);
    evt(0, 0, 0, 0, 1, 16'd4);
    chk_ro("R7 saturate", A_XCNT, 32'd0);
    chk_ro("R7 done set", A_RST, 32'h8);
    wr(A_RST, 32'h8);
    evt(0, 0, 0, 0, 1, 16'd3);
    chk_ro("R7 done at zero", A_RST, 32'h8);
    @(negedge clk); addr = A_BYTE; wdata = 32'd50; we = 1; dec = 1; amt = 16'd7;
    @(negedge clk); we = 0; dec = 0; amt = '0; m_x = 50;
    chk_ro("R7 load wins", A_XCNT, 32'd50);
    wr(A_RST, 32'hFFFF_FFFF);

    // R8 DMA status
    evt(0, 0, 0, 32'hFFFF_FFFF, 0, 0);
    wr(A_DST, 32'hFFFF_FFFF);
    chk_ro("R8 low clear high kept", A_DST, 32'hFFFF_FC00);

    // R10 CRC window, undefined, unaligned, read-only counter
    wr(12'h100, 32'hFFFF_FFFF);
    chk_ro("R10 crc read zero", 12'h100, 32'h0);
    chk_ro("R10 crc last word", 12'h124, 32'h0);
    chk_ro("R10 undefined", 12'h0F0, 32'h0);
    wr(12'h005, 32'h0);
    chk_ro("R10 unaligned write ignored", A_TMO, 32'h1234_5678);
    chk_ro("R10 unaligned read", 12'h005, 32'h0);
    wr(A_XCNT, 32'h55);
    chk_ro("R10 xcnt read-only", A_XCNT, m_x);

    // random traffic against the model
    for (int it = 0; it < 600; it++) begin
      int op;
      op = int'($urandom % 8);
      case (op)
        0: wr(A_MASK, $urandom);
        1: wr(A_CTRL, ($urandom & 32'hFFFF_FFEF) | (($urandom % 2) << 4));
        2: wr(($urandom % 2) ? A_RST : A_MST, $urandom);
        3: evt(0, 0, 32'h1 << ($urandom % 32), 0, 0, 0);
        4: evt($urandom % 2, 0, 0, 0, 0, 0) ;
        5: evt(0, 1, 0, 32'h1 << ($urandom % 32), 1, 16'($urandom % 16));
        6: wr(A_BYTE, $urandom % 64);
        default: wr(A_DST, $urandom);
      endcase
      chk("R2 irq random", {31'b0, irq}, {31'b0, m_irq()});
      if (it % 8 == 7) begin
        chk_ro("R3 raw random", A_RST, m_raw);
        chk_ro("R3 masked random", A_MST, m_raw & m_mask);
        chk_ro("R8 dstat random", A_DST, m_dst);
        chk_ro("R7 xcnt random", A_XCNT, m_x);
        chk_ro("R5 cstat random", A_CST, m_cst);
        chk_ro("R4 ctrl random", A_CTRL, m_ctrl);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule